// File: doc/BRIEF.md
# Descriptor Ring Submission Tracker

This block keeps the bookkeeping for one DMA queue's submission ring, whose size is a power of two. Software hands descriptors to the engine by writing a count to a tail-increment doorbell. The block moves its producer index forward by that count. A fetch port then offers the descriptors one at a time. Each offered descriptor comes with its slot index and with the 2-bit generation tag that the descriptor's control word must carry. Completion acknowledges move the consumer index forward and give slots back.

The generation tag counts passes of the ring modulo four. A completion can then be matched to the pass it belongs to, even after the indices have wrapped. One slot is always held back, so a full ring and an empty ring never share the same index pair. A doorbell the ring cannot hold is refused and sets a sticky error flag. A synchronous clear returns the queue to its starting state.

Top module: `ring_sub_tracker`

## Requirements
- R1: After reset, free_count is SIZE-1 and pending_count, inflight_count, fetch_slot, fetch_gen and overflow_err are all 0, with empty high and fetch_valid low.
- R2: A doorbell with count N, where 1 <= N <= free_count, is accepted. On the next cycle pending_count has grown by N and free_count has shrunk by N.
- R3: free_count + pending_count + inflight_count always equals SIZE-1, so one slot is never used. A doorbell of SIZE is refused even on an empty ring, and SIZE-1 is the largest count accepted.
- R4: A doorbell with count 0, or with a count above free_count, changes no index. It sets overflow_err on the next cycle, and overflow_err then stays high until a queue clear.
- R5: fetch_valid is high exactly when pending_count is nonzero. Each cycle with fetch_valid and fetch_ready both high moves fetch_slot up by one, modulo SIZE.
- R6: fetch_gen starts at 0. It steps by one, modulo 4, in the cycle after the descriptor in slot SIZE-1 is taken. So the descriptor taken as the k-th since clear (k counted from 0) carries tag (k / SIZE) mod 4.
- R7: fetch_tag is a 32-bit control-word fragment. It holds fetch_gen in bits 25:24, and every other bit is 0.
- R8: An acknowledge of M, where 1 <= M <= inflight_count, lowers inflight_count by M and raises free_count by M on the next cycle. An acknowledge of 0, or of more than inflight_count, has no effect and sets no error.
- R9: empty is high exactly when every submitted descriptor has been acknowledged, which is when free_count equals SIZE-1.
- R10: q_clear takes effect at the next clock edge and restores the R1 state. It overrides any doorbell, acknowledge or fetch in the same cycle.
- R11: A doorbell, an acknowledge and a fetch in the same cycle all take effect. Each is judged against the counts as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_clear | input | 1 | Synchronous queue clear |
| db_valid | input | 1 | Doorbell write strobe |
| db_count | input | IDX_W+1 | Number of descriptors handed over |
| ack_valid | input | 1 | Completion acknowledge strobe |
| ack_count | input | IDX_W+1 | Number of descriptors acknowledged |
| fetch_ready | input | 1 | Fetch side takes the offered descriptor |
| fetch_valid | output | 1 | A descriptor is waiting to be fetched |
| fetch_slot | output | IDX_W | Ring slot of the offered descriptor |
| fetch_gen | output | 2 | Ring generation of the offered descriptor |
| fetch_tag | output | 32 | Generation placed at its control-word position |
| free_count | output | IDX_W | Slots software may still fill |
| pending_count | output | IDX_W | Submitted but not yet fetched |
| inflight_count | output | IDX_W | Fetched but not yet acknowledged |
| empty | output | 1 | No descriptor is outstanding |
| overflow_err | output | 1 | Sticky flag for a refused doorbell |

## Verification
Every count, the fetch slot, the generation tag and the error flag come straight from registers. A doorbell, acknowledge, fetch or clear presented before an edge is therefore visible one cycle later and never later than that. fetch_valid and fetch_tag follow the current state with no added delay. The bench drives all inputs on the falling edge and compares every output 1 ns after the following rising edge. Its model is advanced by exactly one transition per edge, using the counts from before that edge, so each comparison lands in the cycle its result is due.

// File: rtl/ring_trk_pkg.sv
package ring_trk_pkg;
  localparam int GEN_W    = 2;
  localparam int CTRL_W   = 32;
  localparam int RID_LSB  = 24;

  function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] g);
    return g + 1'b1;
  endfunction
endpackage

// File: rtl/ring_producer.sv
module ring_producer #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             db_valid,
  input  logic [IDX_W:0]   db_count,
  input  logic [IDX_W-1:0] cons_idx,
  output logic [IDX_W-1:0] prod_idx,
  output logic [IDX_W-1:0] free_cnt,
  output logic             db_accept,
  output logic             db_reject,
  output logic             prod_wrap,
  output logic             overflow
);
  function automatic logic [IDX_W-1:0] slots_free(input logic [IDX_W-1:0] c,
                                                   input logic [IDX_W-1:0] p);
    return c - p - 1'b1;
  endfunction

  logic [IDX_W:0] sum;

  assign free_cnt  = slots_free(cons_idx, prod_idx);
  assign db_accept = db_valid && (db_count != '0) && (db_count <= {1'b0, free_cnt});
  assign db_reject = db_valid && !db_accept;
  assign sum       = {1'b0, prod_idx} + db_count;
  assign prod_wrap = db_accept && sum[IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_idx <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      prod_idx <= '0;
      overflow <= 1'b0;
    end else begin
      if (db_accept) prod_idx <= sum[IDX_W-1:0];
      if (db_reject) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/ring_fetcher.sv
module ring_fetcher #(
  parameter int IDX_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear,
  input  logic [IDX_W-1:0]                  prod_idx,
  input  logic                              fetch_ready,
  output logic                              fetch_valid,
  output logic [IDX_W-1:0]                  fetch_idx,
  output logic [ring_trk_pkg::GEN_W-1:0]    fetch_gen,
  output logic [IDX_W-1:0]                  pending,
  output logic                              fetch_fire,
  output logic                              fetch_wrap
);
  import ring_trk_pkg::*;

  localparam logic [IDX_W-1:0] LAST_SLOT = {IDX_W{1'b1}};

  function automatic logic [IDX_W-1:0] ring_dist(input logic [IDX_W-1:0] ahead,
                                                  input logic [IDX_W-1:0] behind);
    return ahead - behind;
  endfunction

  assign pending     = ring_dist(prod_idx, fetch_idx);
  assign fetch_valid = (prod_idx != fetch_idx);
  assign fetch_fire  = fetch_valid && fetch_ready;
  assign fetch_wrap  = fetch_fire && (fetch_idx == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_idx <= '0;
      fetch_gen <= '0;
    end else if (clear) begin
      fetch_idx <= '0;
      fetch_gen <= '0;
    end else if (fetch_fire) begin
      fetch_idx <= fetch_idx + 1'b1;
      if (fetch_wrap) fetch_gen <= gen_step(fetch_gen);
    end
  end
endmodule

// File: rtl/ring_consumer.sv
module ring_consumer #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ack_valid,
  input  logic [IDX_W:0]   ack_count,
  input  logic [IDX_W-1:0] fetch_idx,
  output logic [IDX_W-1:0] cons_idx,
  output logic [IDX_W-1:0] inflight,
  output logic             ack_accept
);
  function automatic logic [IDX_W-1:0] ring_dist(input logic [IDX_W-1:0] ahead,
                                                  input logic [IDX_W-1:0] behind);
    return ahead - behind;
  endfunction

  assign inflight   = ring_dist(fetch_idx, cons_idx);
  assign ack_accept = ack_valid && (ack_count != '0) && (ack_count <= {1'b0, inflight});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cons_idx <= '0;
    else if (clear)      cons_idx <= '0;
    else if (ack_accept) cons_idx <= cons_idx + ack_count[IDX_W-1:0];
  end
endmodule

// File: rtl/ring_sub_tracker.sv
module ring_sub_tracker #(
  parameter int IDX_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           q_clear,
  input  logic                           db_valid,
  input  logic [IDX_W:0]                 db_count,
  input  logic                           ack_valid,
  input  logic [IDX_W:0]                 ack_count,
  input  logic                           fetch_ready,
  output logic                           fetch_valid,
  output logic [IDX_W-1:0]               fetch_slot,
  output logic [ring_trk_pkg::GEN_W-1:0] fetch_gen,
  output logic [ring_trk_pkg::CTRL_W-1:0] fetch_tag,
  output logic [IDX_W-1:0]               free_count,
  output logic [IDX_W-1:0]               pending_count,
  output logic [IDX_W-1:0]               inflight_count,
  output logic                           empty,
  output logic                           overflow_err
);
  import ring_trk_pkg::*;

  logic [IDX_W-1:0] prod_idx;
  logic [IDX_W-1:0] cons_idx;
  logic             db_accept;
  logic             db_reject;
  logic             prod_wrap;
  logic             fetch_fire;
  logic             fetch_wrap;
  logic             ack_accept;

  ring_producer #(.IDX_W(IDX_W)) u_prod (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (q_clear),
    .db_valid  (db_valid),
    .db_count  (db_count),
    .cons_idx  (cons_idx),
    .prod_idx  (prod_idx),
    .free_cnt  (free_count),
    .db_accept (db_accept),
    .db_reject (db_reject),
    .prod_wrap (prod_wrap),
    .overflow  (overflow_err)
  );

  ring_fetcher #(.IDX_W(IDX_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (q_clear),
    .prod_idx    (prod_idx),
    .fetch_ready (fetch_ready),
    .fetch_valid (fetch_valid),
    .fetch_idx   (fetch_slot),
    .fetch_gen   (fetch_gen),
    .pending     (pending_count),
    .fetch_fire  (fetch_fire),
    .fetch_wrap  (fetch_wrap)
  );

  ring_consumer #(.IDX_W(IDX_W)) u_cons (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (q_clear),
    .ack_valid  (ack_valid),
    .ack_count  (ack_count),
    .fetch_idx  (fetch_slot),
    .cons_idx   (cons_idx),
    .inflight   (inflight_count),
    .ack_accept (ack_accept)
  );

  assign empty = (prod_idx == cons_idx);

  always_comb begin
    fetch_tag = '0;
    fetch_tag[RID_LSB +: GEN_W] = fetch_gen;
  end
endmodule

// File: rtl/ring_sub_tracker_chk.sv
module ring_sub_tracker_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q_clear,
  input logic             fetch_valid,
  input logic [IDX_W-1:0] fetch_slot,
  input logic [1:0]       fetch_gen,
  input logic [31:0]      fetch_tag,
  input logic [IDX_W-1:0] free_count,
  input logic [IDX_W-1:0] pending_count,
  input logic [IDX_W-1:0] inflight_count,
  input logic             empty,
  input logic             overflow_err,
  input logic [IDX_W-1:0] prod_idx,
  input logic             db_reject,
  input logic             fetch_fire,
  input logic             prod_wrap
);
  localparam int SIZE = 1 << IDX_W;

  p_slot_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(free_count) + 32'(pending_count) + 32'(inflight_count)) == SIZE - 1);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (db_reject && !q_clear) |=> ($stable(prod_idx) && overflow_err));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_err && !q_clear) |=> overflow_err);

  p_valid_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid == (pending_count != '0));

  p_fetch_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_fire && !q_clear) |=> (fetch_slot == $past(fetch_slot) + 1'b1));

  p_gen_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_fire && !q_clear && (fetch_slot == {IDX_W{1'b1}}))
      |=> (fetch_gen == $past(fetch_gen) + 1'b1));

  p_tag_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_tag[25:24] == fetch_gen) && ((fetch_tag & 32'hFCFF_FFFF) == 32'h0));

  p_empty_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (32'(free_count) == SIZE - 1));

  p_clear_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_clear |=> (empty && !fetch_valid && fetch_gen == 2'd0 && !overflow_err
                 && !prod_wrap && fetch_slot == '0));
endmodule

bind ring_sub_tracker ring_sub_tracker_chk #(.IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .q_clear        (q_clear),
  .fetch_valid    (fetch_valid),
  .fetch_slot     (fetch_slot),
  .fetch_gen      (fetch_gen),
  .fetch_tag      (fetch_tag),
  .free_count     (free_count),
  .pending_count  (pending_count),
  .inflight_count (inflight_count),
  .empty          (empty),
  .overflow_err   (overflow_err),
  .prod_idx       (prod_idx),
  .db_reject      (db_reject),
  .fetch_fire     (fetch_fire),
  .prod_wrap      (prod_wrap)
);

// File: tb/tb_ring_sub_tracker.sv
module tb_ring_sub_tracker;
  localparam int IDX_W = 4;
  localparam int SIZE  = 1 << IDX_W;
  localparam int MASK  = SIZE - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             q_clear = 1'b0;
  logic             db_valid = 1'b0;
  logic [IDX_W:0]   db_count = '0;
  logic             ack_valid = 1'b0;
  logic [IDX_W:0]   ack_count = '0;
  logic             fetch_ready = 1'b0;
  logic             fetch_valid;
  logic [IDX_W-1:0] fetch_slot;
  logic [1:0]       fetch_gen;
  logic [31:0]      fetch_tag;
  logic [IDX_W-1:0] free_count;
  logic [IDX_W-1:0] pending_count;
  logic [IDX_W-1:0] inflight_count;
  logic             empty;
  logic             overflow_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_prod, m_fetch, m_cons, m_total;
  bit m_err;

  always #4 clk = ~clk;

  ring_sub_tracker #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .q_clear(q_clear),
    .db_valid(db_valid), .db_count(db_count),
    .ack_valid(ack_valid), .ack_count(ack_count),
    .fetch_ready(fetch_ready), .fetch_valid(fetch_valid),
    .fetch_slot(fetch_slot), .fetch_gen(fetch_gen), .fetch_tag(fetch_tag),
    .free_count(free_count), .pending_count(pending_count),
    .inflight_count(inflight_count), .empty(empty), .overflow_err(overflow_err)
  );

  function automatic int exp_free();     return (m_cons - m_prod - 1) & MASK; endfunction
  function automatic int exp_pending();  return (m_prod - m_fetch) & MASK;    endfunction
  function automatic int exp_inflight(); return (m_fetch - m_cons) & MASK;    endfunction
  function automatic int exp_gen();      return (m_total / SIZE) % 4;         endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string pick(string tag, string dflt);
    return (tag == "") ? dflt : tag;
  endfunction

  task automatic verify(string tag);
    chk(pick(tag, "R2"), "free_count", int'(free_count), exp_free());
    chk(pick(tag, "R2"), "pending_count", int'(pending_count), exp_pending());
    chk(pick(tag, "R8"), "inflight_count", int'(inflight_count), exp_inflight());
    chk(pick(tag, "R3"), "slot_sum",
        int'(free_count) + int'(pending_count) + int'(inflight_count), SIZE - 1);
    chk(pick(tag, "R9"), "empty", int'(empty), int'(m_prod == m_cons));
    chk(pick(tag, "R5"), "fetch_valid", int'(fetch_valid), int'(m_prod != m_fetch));
    chk(pick(tag, "R5"), "fetch_slot", int'(fetch_slot), m_fetch);
    chk(pick(tag, "R6"), "fetch_gen", int'(fetch_gen), exp_gen());
    chk(pick(tag, "R7"), "fetch_tag", int'(fetch_tag), exp_gen() << 24);
    chk(pick(tag, "R4"), "overflow_err", int'(overflow_err), int'(m_err));
  endtask

  task automatic step(bit dv, int dn, bit av, int an, bit fr, bit clr, string tag);
    int fr_pre, inf_pre;
    bit fire;
    @(negedge clk);
    db_valid = dv; db_count = (IDX_W+1)'(dn);
    ack_valid = av; ack_count = (IDX_W+1)'(an);
    fetch_ready = fr; q_clear = clr;
    fr_pre = exp_free();
    inf_pre = exp_inflight();
    fire = fr && (m_prod != m_fetch);
    @(posedge clk);
    #1;
    if (clr) begin
      m_prod = 0; m_fetch = 0; m_cons = 0; m_total = 0; m_err = 0;
    end else begin
      if (dv) begin
        if (dn >= 1 && dn <= fr_pre) m_prod = (m_prod + dn) & MASK;
        else m_err = 1;
      end
      if (av && an >= 1 && an <= inf_pre) m_cons = (m_cons + an) & MASK;
      if (fire) begin
        m_fetch = (m_fetch + 1) & MASK;
        m_total++;
      end
    end
    verify(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished t=%0t", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    m_prod = 0; m_fetch = 0; m_cons = 0; m_total = 0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    verify("R1");

    // R2: accepted doorbell
    step(1, 5, 0, 0, 0, 0, "R2");
    // R4: zero count refused, sticky
    step(1, 0, 0, 0, 0, 0, "R4");
    idle("R4");
    // R10: clear with a competing doorbell
    step(1, 3, 0, 0, 1, 1, "R10");
    // R3: full-size doorbell refused on empty ring
    step(1, SIZE, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, "R10");
    // R3: largest doorbell accepted, then ring full
    step(1, SIZE - 1, 0, 0, 0, 0, "R3");
    step(1, 1, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 1, "R1");
    // R8: over-acknowledge ignored
    step(1, 3, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 0, "R5");
    step(0, 0, 0, 0, 1, 0, "R5");
    step(0, 0, 1, 3, 0, 0, "R8");
    step(0, 0, 1, 0, 0, 0, "R8");
    step(0, 0, 1, 2, 0, 0, "R8");
    // R11: doorbell, ack and fetch together
    step(1, 4, 1, 1, 1, 0, "R11");
    step(1, 2, 1, 1, 1, 0, "R11");
    step(0, 0, 0, 0, 0, 1, "R10");
    // R6: several generation wraps
    for (int i = 0; i < 160; i++) begin
      int f, inf;
      f = exp_free();
      inf = exp_inflight();
      step(f >= 4, 4, inf > 0, inf, 1, 0, "R6");
    end
    step(0, 0, 0, 0, 0, 1, "R10");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int dn, an, inf;
      bit dv, av, fr, clr;
      inf = exp_inflight();
      dv  = ($urandom_range(0, 2) != 0);
      dn  = ($urandom_range(0, 9) == 0) ? $urandom_range(0, SIZE) : $urandom_range(1, 4);
      av  = ($urandom_range(0, 2) == 0);
      an  = $urandom_range(0, inf + 1);
      fr  = ($urandom_range(0, 3) != 0);
      clr = ($urandom_range(0, 299) == 0);
      step(dv, dn, av, an, fr, clr, "");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule